// File: doc/BRIEF.md
# Four-Lane Block FIR Filter with Shared Sub-Filters

This block is a fixed-coefficient FIR filter that takes a block of four consecutive signed samples on each valid clock and returns the four matching filtered samples. It is meant for sample streams that run four times faster than the clock. It does not build sixteen polyphase products. Instead it applies the two-phase fast FIR split twice, one level inside the other. Sharing the sub-filters this way leaves nine short sub-filters, each a quarter of the full tap count long. Small adder networks sit in front of the sub-filters to form summed input phases, and behind them to rebuild the four output phases. Four block-level registers carry terms from one block to the next.

The coefficients are a packed parameter vector, with tap t held in bits [t*CW +: CW]. All arithmetic is exact. The output lanes are wide enough to hold any convolution sum without wrap. The filter has no feedback path. A stall on the valid input freezes the filter state. An asynchronous active-low reset returns the filter to an all-zero history.

Top module: `fir4_fast`

## Requirements
- R1: On every clock with in_valid high the block accepts one block of four samples. Back-to-back valid blocks on consecutive clocks are all processed, with no bubble.
- R2: For every accepted sample index n, the output equals the exact signed sum over t = 0..NTAPS-1 of h[t]·x[n-t]. Samples before the first one accepted since reset count as zero.
- R3: out_valid rises exactly two clock cycles after the in_valid of the same block. All four output lanes of that block appear together in that cycle.
- R4: A clock with in_valid low leaves the filter history unchanged, whatever in_data holds. out_data holds its last value while out_valid is low, and the next valid block is filtered as if the gap had not occurred.
- R5: While rst_n is low, out_valid is 0, out_data is 0 and the whole sample history is cleared.
- R6: An impulse gives a finite response. After NTAPS/4+1 consecutive all-zero valid blocks, the output block is exactly zero.
- R7: Output lanes are OW = W+CW+log2(NTAPS) bits wide. Full-scale inputs of either sign give the exact result with no wrap or saturation.
- R8: Lane i (bits [i*W +: W] of in_data, i = 0..3) carries sample 4k+i of block k, so lane 0 is the oldest sample. Output lane i (bits [i*OW +: OW] of out_data) carries output 4k+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input block is present this cycle |
| in_data | input | 4*W | Four signed samples, lane 0 oldest |
| out_valid | output | 1 | The output block is present |
| out_data | output | 4*OW | Four signed filtered samples, lane 0 oldest |

## Verification
Single impulses placed in lane 0 and in lane 2 show each coefficient in its own output position. They expose any swapped sub-filter, lost delay term or lane misordering, and they show the response dying out after a fixed number of blocks. Dense random blocks exercise every recombination path at once. Random valid gaps with junk data on idle cycles separate a correct stall from history that advances or absorbs idle data. Full-scale blocks of both signs, and a reset in mid-stream followed by an impulse, check exact wide arithmetic and a return to a zero initial state.

// File: rtl/fir4_fast.sv
module fir4_fast #(
  parameter int NTAPS = 8,
  parameter int W = 16,
  parameter int CW = 16,
  parameter logic [NTAPS*CW-1:0] COEFS = 128'h7FFF_FFF7_00FA_8000_03E8_0078_FFFB_0003,
  localparam int OW = W + CW + $clog2(NTAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4*W-1:0]  in_data,
  output logic            out_valid,
  output logic [4*OW-1:0] out_data
);
  // NTAPS must be a multiple of 4 and at least 8
  localparam int LT = NTAPS / 4;
  localparam int UW = W + 2;
  localparam int GW = CW + 2;
  localparam int SW = UW + GW + $clog2(LT);
  localparam int AW = SW + 2;

  // phase set per sub-filter: a0 a2 a02 b1 b3 b13 c0 c2 c02
  localparam logic [3:0] MASK [9] = '{4'b0001, 4'b0100, 4'b0101, 4'b0010, 4'b1000,
                                      4'b1010, 4'b0011, 4'b1100, 4'b1111};

  function automatic logic signed [GW-1:0] gco(input int j, input int m);
    logic signed [GW-1:0] s;
    s = '0;
    for (int i = 0; i < 4; i++)
      if (MASK[j][i]) s += GW'($signed(COEFS[(4*m+i)*CW +: CW]));
    return s;
  endfunction

  logic signed [W-1:0]  x   [4];
  logic signed [UW-1:0] u   [9];
  logic signed [UW-1:0] dly [9][LT-1];
  logic signed [SW-1:0] sub [9];
  logic signed [SW-1:0] sr  [9];
  logic signed [AW-1:0] e   [9];
  logic signed [AW-1:0] d_a2, d_b3, d_c2, d_po1;
  logic signed [OW-1:0] yq  [4];
  logic v1;

  always_comb begin
    for (int i = 0; i < 4; i++) x[i] = $signed(in_data[i*W +: W]);
    u[0] = UW'(x[0]);
    u[1] = UW'(x[2]);
    u[2] = UW'(x[0]) + UW'(x[2]);
    u[3] = UW'(x[1]);
    u[4] = UW'(x[3]);
    u[5] = UW'(x[1]) + UW'(x[3]);
    u[6] = UW'(x[0]) + UW'(x[1]);
    u[7] = UW'(x[2]) + UW'(x[3]);
    u[8] = u[6] + u[7];
  end

  always_comb
    for (int j = 0; j < 9; j++) begin
      sub[j] = SW'(u[j]) * SW'(gco(j, 0));
      for (int m = 1; m < LT; m++) sub[j] += SW'(dly[j][m-1]) * SW'(gco(j, m));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0;
      for (int j = 0; j < 9; j++) begin
        sr[j] <= '0;
        for (int m = 0; m < LT-1; m++) dly[j][m] <= '0;
      end
    end else begin
      v1 <= in_valid;
      if (in_valid)
        for (int j = 0; j < 9; j++) begin
          sr[j] <= sub[j];
          dly[j][0] <= u[j];
          for (int m = 1; m < LT-1; m++) dly[j][m] <= dly[j][m-1];
        end
    end

  always_comb
    for (int j = 0; j < 9; j++) e[j] = AW'(sr[j]);

  wire signed [AW-1:0] pe1 = e[2] - e[0] - e[1];
  wire signed [AW-1:0] po1 = e[5] - e[3] - e[4];
  wire signed [AW-1:0] pc1 = e[8] - e[6] - e[7];
  wire signed [AW-1:0] sa  = e[0] + d_a2;
  wire signed [AW-1:0] tb  = e[3] + d_b3;
  wire signed [AW-1:0] y0n = sa + d_po1;
  wire signed [AW-1:0] y1n = e[6] + d_c2 - sa - tb;
  wire signed [AW-1:0] y2n = pe1 + tb;
  wire signed [AW-1:0] y3n = pc1 - pe1 - po1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      d_a2 <= '0; d_b3 <= '0; d_c2 <= '0; d_po1 <= '0;
      for (int i = 0; i < 4; i++) yq[i] <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        d_a2  <= e[1];
        d_b3  <= e[4];
        d_c2  <= e[7];
        d_po1 <= po1;
        yq[0] <= y0n[OW-1:0];
        yq[1] <= y1n[OW-1:0];
        yq[2] <= y2n[OW-1:0];
        yq[3] <= y3n[OW-1:0];
      end
    end

  always_comb
    for (int i = 0; i < 4; i++) out_data[i*OW +: OW] = yq[i];
endmodule

// File: rtl/fir4_fast_chk.sv
module fir4_fast_chk #(
  parameter int W = 16,
  parameter int OW = 35,
  parameter int LT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [4*W-1:0]  in_data,
  input logic            out_valid,
  input logic [4*OW-1:0] out_data
);
  logic [1:0] since;
  int zrun, z_s1, z_s2, znext;

  always_comb
    if (!in_valid) znext = zrun;
    else if (in_data != '0) znext = 0;
    else znext = (zrun > LT + 1) ? zrun : zrun + 1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      since <= '0; zrun <= 0; z_s1 <= 0; z_s2 <= 0;
    end else begin
      if (since != 2'd2) since <= since + 2'd1;
      zrun <= znext;
      z_s1 <= znext;
      z_s2 <= z_s1;
    end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    since == 2'd2 |-> out_valid == $past(in_valid, 2));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  assert_reset_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    since != 2'd2 |-> !out_valid);
  assert_reset_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    since == 2'd0 |-> out_data == '0);
  assert_finite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && z_s2 > LT) |-> out_data == '0);
endmodule

bind fir4_fast fir4_fast_chk #(.W(W), .OW(OW), .LT(NTAPS/4)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_fir4_fast.sv
`timescale 1ns/1ps
module tb_fir4_fast;
  localparam int NT = 8;
  localparam int W = 16;
  localparam int CW = 16;
  localparam int OW = W + CW + $clog2(NT);
  localparam int LT = NT / 4;
  localparam logic [NT*CW-1:0] CO = 128'h7FFF_FFF7_00FA_8000_03E8_0078_FFFB_0003;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [4*W-1:0] in_data = '0;
  wire out_valid;
  wire [4*OW-1:0] out_data;

  fir4_fast #(.NTAPS(NT), .W(W), .CW(CW), .COEFS(CO)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int nrun = 0, nfail = 0;
  bit done = 0;
  string tag = "R5";
  longint hq[$];
  longint s1d[4], eod[4];
  bit s1v = 0, eov = 0;

  function automatic longint coef(int t);
    return longint'($signed(CO[t*CW +: CW]));
  endfunction

  function automatic longint lane(int i);
    return longint'($signed(out_data[i*OW +: OW]));
  endfunction

  task automatic chk(bit ok, string r, longint got, longint exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  // behavioural model: history of accepted samples, two-stage delay
  always @(posedge clk) begin
    if (!rst_n) begin
      hq.delete(); s1v = 0; eov = 0;
      for (int i = 0; i < 4; i++) eod[i] = 0;
    end else begin
      if (s1v) for (int i = 0; i < 4; i++) eod[i] = s1d[i];
      eov = s1v;
      s1v = in_valid;
      if (in_valid)
        for (int i = 0; i < 4; i++) begin
          longint acc;
          int n;
          hq.push_back(longint'($signed(in_data[i*W +: W])));
          n = hq.size() - 1;
          acc = 0;
          for (int t = 0; t < NT; t++) if (n - t >= 0) acc += coef(t) * hq[n-t];
          s1d[i] = acc;
        end
    end
  end

  always @(negedge clk)
    if (rst_n && !done) begin
      chk(out_valid == eov, "R3", longint'(out_valid), longint'(eov));
      for (int i = 0; i < 4; i++) chk(lane(i) == eod[i], tag, lane(i), eod[i]);
    end

  task automatic send(bit v, longint a, longint b, longint c, longint d);
    @(negedge clk);
    in_valid = v;
    in_data[0*W +: W] = W'(a);
    in_data[1*W +: W] = W'(b);
    in_data[2*W +: W] = W'(c);
    in_data[3*W +: W] = W'(d);
  endtask

  function automatic longint rnd();
    return longint'($signed(16'($urandom)));
  endfunction

  function automatic longint ext();
    return ($urandom % 2) ? 32767 : -32768;
  endfunction

  task automatic idle(int n);
    for (int k = 0; k < n; k++) send(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R5", longint'(out_valid), 0);
    chk(out_data == '0, "R5", lane(0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R5", longint'(out_valid), 0);
    chk(out_data == '0, "R5", lane(0), 0);

    tag = "R6";
    send(1, 1, 0, 0, 0);
    for (int k = 0; k < LT + 2; k++) send(1, 0, 0, 0, 0);
    idle(3);
    for (int i = 0; i < 4; i++) chk(lane(i) == 0, "R6", lane(i), 0);

    tag = "R8";
    send(1, 0, 0, 5, 0);
    for (int k = 0; k < LT + 1; k++) send(1, 0, 0, 0, 0);
    idle(3);

    tag = "R1";
    for (int k = 0; k < 40; k++) send(1, rnd(), rnd(), rnd(), rnd());
    idle(3);

    tag = "R4";
    for (int k = 0; k < 80; k++) send(($urandom % 2) == 1, rnd(), rnd(), rnd(), rnd());
    idle(3);

    tag = "R7";
    for (int k = 0; k < 40; k++) send(1, ext(), ext(), ext(), ext());
    for (int k = 0; k < 4; k++) send(1, -32768, -32768, -32768, -32768);
    for (int k = 0; k < 4; k++) send(1, 32767, 32767, 32767, 32767);
    idle(3);

    tag = "R2";
    for (int k = 0; k < 20; k++) send(1, rnd(), rnd(), rnd(), rnd());
    do_reset();
    tag = "R5";
    send(1, 0, 1, 0, 0);
    for (int k = 0; k < LT + 1; k++) send(1, 0, 0, 0, 0);
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nrun++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule